// File: doc/BRIEF.md
# Three-Wire Serial Control Register Bank

This block receives configuration words over a three-wire bus made of a data line, a bit clock and a latch strobe. It oversamples all three pins with the fast system clock and shifts in one bit on each detected rising edge of the bit clock. Each frame is 18 bits long and is sent least significant bit first: sixteen data bits, then two address bits. A rising edge on the latch strobe writes the sixteen data bits into the addressed register, which is one of four. The decoded fields drive the frequency synthesiser counters, the test-path selects, the clock-output enable and the filter select.

While the enable input is low, the bank ignores bus traffic. During that time every register tracks a default profile. The profile is chosen from the static levels on the three bus pins, which act as straps. When enable rises, the profile in force at that moment stays in place until software overwrites it. A host therefore does not have to program anything if one of the two built-in reference/IF combinations is wanted.

Top module: `serial_ctrl_regs`

## Requirements
- R1: A frame is taken bit by bit on rising edges of `sclk`, least significant bit first: data bits 0 to 15, then address bit 0, then address bit 1.
- R2: A rising edge of `slat` while `en` is high writes the 16 data bits into the register selected by the two address bits. The affected outputs are updated within 4 system clocks of that edge on the pin, and the other three registers keep their contents.
- R3: While `en` is high and no latch edge occurs, the register contents and the field outputs do not change, even while bits are being shifted in.
- R4: When more than 18 bits arrive before a latch edge, only the last 18 bits received form the frame.
- R5: Address 0: `main_cnt` is data bits 15..5, and `clkout_en` is data bit 1 (1 turns the clock output on).
- R6: Address 1: `swal_cnt` is data bits 15..11, and `ref_cnt` is data bits 10..2.
- R7: Address 2: `tin_sel` is data bits 15..13, `tout_sel` is data bits 12..10 (code 0 selects normal operation), and `filt_sel` is data bit 1 (0 selects the normal low-pass mode). Address 3: `test_en` is data bit 0.
- R8: While `en` is low, bus frames and latch edges have no effect. Registers 2 and 3 and `clkout_en` stay at zero, and registers 0 and 1 follow the strap profile.
- R9: Strap levels data=1, clock=0, latch=0 select the 18.414 MHz reference / 1.023 MHz IF profile: `main_cnt`=7, `swal_cnt`=3, `ref_cnt`=4. This profile is kept after `en` rises.
- R10: Strap levels data=1, clock=1, latch=0 select the 13 MHz / 0.976 MHz profile: `main_cnt`=22, `swal_cnt`=17, `ref_cnt`=9.
- R11: Any other strap combination, including all low, gives all-zero counter fields.
- R12: While `rst_n` is low, every field output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operating enable; low holds the strap defaults |
| sdata | input | 1 | Serial data pin, also a strap |
| sclk | input | 1 | Serial bit clock pin, also a strap |
| slat | input | 1 | Latch strobe pin, also a strap |
| main_cnt | output | 11 | Main divider value |
| swal_cnt | output | 5 | Swallow counter value |
| ref_cnt | output | 9 | Reference divider value |
| tin_sel | output | 3 | Test input location select |
| tout_sel | output | 3 | Test output location select |
| clkout_en | output | 1 | Reference clock output enable |
| filt_sel | output | 1 | Internal filter mode select |
| test_en | output | 1 | Test path enable |

## Verification
The hardest case to reach is the disabled state. In that state the bus pins serve two purposes at once: they carry frames that must be ignored, and they are the straps that choose the defaults. The stimulus sends a complete frame with a latch pulse while `en` is low, and the frame targets the test-enable register. The pins then come to rest on the second profile's levels. The check confirms that only the profile appears and that test mode stays off. Then `en` rises and the pins are driven back to zero, which shows that the profile latched at the rise survives later pin activity.

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        sdata,
  input  logic        sclk,
  input  logic        slat,
  output logic [10:0] main_cnt,
  output logic [4:0]  swal_cnt,
  output logic [8:0]  ref_cnt,
  output logic [2:0]  tin_sel,
  output logic [2:0]  tout_sel,
  output logic        clkout_en,
  output logic        filt_sel,
  output logic        test_en
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int NREG    = 1 << ADDR_W;

  logic [2:0] meta, sync, prev;
  logic [FRAME_W-1:0] sh;
  logic [NREG-1:0][DATA_W-1:0] bank;
  logic [DATA_W-1:0] dflt0, dflt1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= {slat, sclk, sdata};
      sync <= meta;
      prev <= sync;
    end

  wire clk_rise = sync[1] & ~prev[1];
  wire lat_rise = sync[2] & ~prev[2];

  always_comb begin
    dflt0 = '0;
    dflt1 = '0;
    case (sync)
      3'b001: begin
        dflt0[15:5]  = 11'd7;
        dflt1[15:11] = 5'd3;
        dflt1[10:2]  = 9'd4;
      end
      3'b011: begin
        dflt0[15:5]  = 11'd22;
        dflt1[15:11] = 5'd17;
        dflt1[10:2]  = 9'd9;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '0;
      bank <= '0;
    end else if (!en) begin
      bank    <= '0;
      bank[0] <= dflt0;
      bank[1] <= dflt1;
    end else begin
      if (clk_rise) sh <= {sync[0], sh[FRAME_W-1:1]};
      if (lat_rise) bank[sh[FRAME_W-1:DATA_W]] <= sh[DATA_W-1:0];
    end

  assign main_cnt  = bank[0][15:5];
  assign clkout_en = bank[0][1];
  assign swal_cnt  = bank[1][15:11];
  assign ref_cnt   = bank[1][10:2];
  assign tin_sel   = bank[2][15:13];
  assign tout_sel  = bank[2][12:10];
  assign filt_sel  = bank[2][1];
  assign test_en   = bank[3][0];

  p_shift_only_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && clk_rise) |=> $stable(sh));

  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lat_rise) |=> $countones({bank[0] != $past(bank[0]), bank[1] != $past(bank[1]),
                                     bank[2] != $past(bank[2]), bank[3] != $past(bank[3])}) <= 1);

  p_hold_without_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lat_rise) |=> $stable(bank));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tin_sel == 3'd0 && tout_sel == 3'd0 && !clkout_en && !filt_sel && !test_en));
endmodule

// File: tb/test_serial_ctrl_regs.sv
module test_serial_ctrl_regs;
  logic clk = 0, rst_n = 0, en = 0, sdata = 0, sclk = 0, slat = 0;
  logic [10:0] main_cnt;
  logic [4:0]  swal_cnt;
  logic [8:0]  ref_cnt;
  logic [2:0]  tin_sel, tout_sel;
  logic        clkout_en, filt_sel, test_en;

  always #2.5 clk = ~clk;

  serial_ctrl_regs i_serial_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .en(en), .sdata(sdata), .sclk(sclk), .slat(slat),
    .main_cnt(main_cnt), .swal_cnt(swal_cnt), .ref_cnt(ref_cnt),
    .tin_sel(tin_sel), .tout_sel(tout_sel),
    .clkout_en(clkout_en), .filt_sel(filt_sel), .test_en(test_en));

  typedef struct {
    logic [33:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [15:0] model [4];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [33:0] pack_model();
    return {model[0][15:5], model[1][15:11], model[1][10:2], model[2][15:13],
            model[2][12:10], model[0][1], model[2][1], model[3][0]};
  endfunction

  wire [33:0] observed = {main_cnt, swal_cnt, ref_cnt, tin_sel, tout_sel,
                          clkout_en, filt_sel, test_en};

  initial forever begin
    exp_t e;
    wait (q.size() != 0);
    @(negedge clk);
    e = q.pop_front();
    checks++;
    if (observed !== e.val) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", e.tag, observed, e.val);
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.val = pack_model();
    e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdata = b;
    gap(12);
    sclk = 1;
    gap(12);
    sclk = 0;
  endtask

  task automatic latch();
    gap(12);
    slat = 1;
    gap(24);
    slat = 0;
    gap(12);
  endtask

  task automatic send(input logic [1:0] a, input logic [15:0] d);
    logic [17:0] w;
    w = {a, d};
    for (int i = 0; i < 18; i++) put_bit(w[i]);
    sdata = 0;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    send(a, d);
    latch();
    if (en) model[a] = d;
  endtask

  task automatic set_profile(input logic [2:0] s);
    model[0] = 16'h0; model[1] = 16'h0; model[2] = 16'h0; model[3] = 16'h0;
    if (s == 3'b001) begin model[0] = 16'h00E0; model[1] = 16'h1810; end
    if (s == 3'b011) begin model[0] = 16'h02C0; model[1] = 16'h8824; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    set_profile(3'b000);
    gap(3);
    expect_now("R12 reset state");
    rst_n = 1;
    gap(10);
    expect_now("R11 all-low straps reserved");

    sdata = 1; sclk = 1;
    gap(10);
    set_profile(3'b011);
    expect_now("R11 R10 straps data/clk high");
    sclk = 1; slat = 1;
    gap(10);
    set_profile(3'b000);
    expect_now("R11 latch strap high reserved");
    slat = 0; sclk = 0; sdata = 1;
    gap(10);
    set_profile(3'b001);
    expect_now("R9 strap data high profile");
    en = 1;
    gap(4);
    sdata = 0;
    gap(10);
    expect_now("R9 profile kept after enable");

    write_reg(2'd0, 16'hFFE2);
    expect_now("R5 R2 main counter and clock-out");
    write_reg(2'd1, 16'hA5A4);
    expect_now("R6 R2 swallow and reference");
    write_reg(2'd2, 16'h9402);
    expect_now("R7 R2 test selects and filter");
    write_reg(2'd3, 16'h0001);
    expect_now("R7 R2 test enable");
    write_reg(2'd1, 16'h5A58);
    expect_now("R1 R6 alternate bit pattern");
    write_reg(2'd0, 16'h0020);
    expect_now("R1 R5 single low main bit");

    send(2'd2, 16'h0000);
    gap(10);
    expect_now("R3 shifted without latch holds");

    put_bit(1); put_bit(1); put_bit(0); put_bit(1);
    write_reg(2'd3, 16'h0000);
    expect_now("R4 extra leading bits dropped");

    write_reg(2'd2, 16'hFC02);
    expect_now("R7 all-ones selects");

    en = 0;
    gap(2);
    send(2'd3, 16'h0001);
    latch();
    sdata = 1; sclk = 1; slat = 0;
    gap(10);
    set_profile(3'b011);
    expect_now("R8 disabled bus frame ignored");
    expect_now("R10 second profile fields");
    en = 1;
    gap(4);
    sdata = 0; sclk = 0;
    gap(10);
    expect_now("R10 profile kept after enable");
    write_reg(2'd3, 16'h0001);
    expect_now("R2 write after re-enable");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule